// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is a small, fully associative translation buffer that turns a 32-bit effective address into a real address. Every entry holds an address-space bit, an 8-bit process tag, an effective page number, a page-size code and a real page number. A lookup forms its key from the incoming address-space bit, the effective address and three process-ID values, so three candidate virtual addresses are tested against every entry in the same cycle.

Each entry sets its own page size, from 4 KB up to 256 MB in steps of four. That size decides how many upper address bits take part in the tag compare and how many low bits pass straight through as the byte offset. The match is combinational and the outcome (hit, miss and real address) is registered, so it appears one clock after the request. Entries are loaded through a single write port, and one input wipes every valid bit at once.

Top module: `vtlb_top`

## Requirements
- R1: After reset hit_o, miss_o and ra_o are all zero and every entry is invalid, so the first lookup misses.
- R2: A lookup presented with req_i high yields exactly one of hit_o or miss_o on the following clock edge; with req_i low both flags are low and ra_o is zero on that edge.
- R3: An entry matches only when its stored address-space bit equals as_i.
- R4: The process tag matches when it equals any of the three slices of pid_i (slice k is bits 8k+7:8k); a stored tag of zero matches any process ID.
- R5: Size code s (wr_size_i) gives a page of 4 KB times 4 to the power s; only effective-address bits 31 down to 12+2s are compared. Codes above 8 act as 8 (256 MB).
- R6: On a hit, ra_o takes bits RA_W-1 down to 12+2s from the entry's real page number placed at bit 12, and bits below 12+2s from ea_i; RA_W is a parameter (32 or 36).
- R7: When several valid entries match, the one with the lowest index supplies the result.
- R8: On a miss ra_o is zero.
- R9: A write with wr_en_i updates entry wr_idx_i on the clock edge; wr_valid_i low removes the entry; a lookup in the same cycle as a write still sees the old contents.
- R10: inval_all_i clears every valid bit on the clock edge and takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| ea_i | input | 32 | Effective address |
| as_i | input | 1 | Address-space bit of the lookup |
| pid_i | input | 24 | Three 8-bit process IDs, slice 0 in the low byte |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 4 | Entry index to write |
| wr_valid_i | input | 1 | Valid bit to store |
| wr_as_i | input | 1 | Address-space bit to store |
| wr_pid_i | input | 8 | Process tag to store, zero for global |
| wr_epn_i | input | 20 | Effective page number (address bits 31:12) |
| wr_size_i | input | 4 | Page-size code |
| wr_rpn_i | input | RA_W-12 | Real page number (real address bits above 12) |
| inval_all_i | input | 1 | Clear all valid bits |
| hit_o | output | 1 | Registered hit flag |
| miss_o | output | 1 | Registered miss flag |
| ra_o | output | RA_W | Registered real address |

## Verification
The bench builds the block with RA_W set to 36 and the default sixteen entries and three process IDs. The wide real address lets real page numbers carry bits above bit 31, so a result that dropped or shifted the upper real-address bits is caught, while the full sixteen-entry array lets overlapping mappings at low and high indices test the priority order. Random lookups aimed near stored pages with random offsets and sizes reach every size code, including the clamped ones above 8.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;
  localparam int unsigned MIN_OFF  = 12;
  localparam int unsigned MAX_CODE = 8;

  function automatic int unsigned off_bits(input int unsigned code);
    int unsigned c;
    c = (code > MAX_CODE) ? MAX_CODE : code;
    return MIN_OFF + 2 * c;
  endfunction
endpackage

// File: rtl/vtlb_entry.sv
`timescale 1ns/1ps
module vtlb_entry #(
  parameter int unsigned EA_W    = 32,
  parameter int unsigned PID_W   = 8,
  parameter int unsigned NUM_PID = 3,
  parameter int unsigned RPN_W   = 20,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned MY_IDX  = 0,
  localparam int unsigned EPN_W  = EA_W - vtlb_pkg::MIN_OFF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic                     wr_valid_i,
  input  logic                     wr_as_i,
  input  logic [PID_W-1:0]         wr_pid_i,
  input  logic [EPN_W-1:0]         wr_epn_i,
  input  logic [SIZE_W-1:0]        wr_size_i,
  input  logic [RPN_W-1:0]         wr_rpn_i,
  input  logic                     inval_all_i,
  input  logic                     as_i,
  input  logic [EPN_W-1:0]         epn_i,
  input  logic [NUM_PID*PID_W-1:0] pid_i,
  output logic                     match_o,
  output logic [SIZE_W-1:0]        size_o,
  output logic [RPN_W-1:0]         rpn_o
);
  logic               valid_q, as_q;
  logic [PID_W-1:0]   pid_q;
  logic [EPN_W-1:0]   epn_q;
  logic [SIZE_W-1:0]  size_q;
  logic [RPN_W-1:0]   rpn_q;

  wire sel_w = wr_en_i && (wr_idx_i == IDX_W'(MY_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      as_q    <= 1'b0;
      pid_q   <= '0;
      epn_q   <= '0;
      size_q  <= '0;
      rpn_q   <= '0;
    end else if (inval_all_i) begin
      valid_q <= 1'b0;
    end else if (sel_w) begin
      valid_q <= wr_valid_i;
      as_q    <= wr_as_i;
      pid_q   <= wr_pid_i;
      epn_q   <= wr_epn_i;
      size_q  <= wr_size_i;
      rpn_q   <= wr_rpn_i;
    end
  end

  // compare mask over page-number bits: offset bits above bit 12 drop out
  logic [EPN_W-1:0] cmp_mask;
  always_comb begin
    int unsigned skip;
    skip = vtlb_pkg::off_bits(int'(size_q)) - vtlb_pkg::MIN_OFF;
    for (int j = 0; j < EPN_W; j++) cmp_mask[j] = (j >= int'(skip));
  end

  logic pid_hit;
  always_comb begin
    pid_hit = (pid_q == '0);
    for (int k = 0; k < NUM_PID; k++)
      if (pid_i[k*PID_W +: PID_W] == pid_q) pid_hit = 1'b1;
  end

  assign match_o = valid_q && (as_q == as_i) && pid_hit &&
                   (((epn_q ^ epn_i) & cmp_mask) == '0);
  assign size_o  = size_q;
  assign rpn_o   = rpn_q;

  p_write_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_w && !inval_all_i) |=> (valid_q == $past(wr_valid_i)));
  p_inval_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_all_i |=> !valid_q);
  p_as_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && as_q != as_i) |-> !match_o);
endmodule

// File: rtl/vtlb_prio.sv
`timescale 1ns/1ps
module vtlb_prio #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] match_i,
  output logic [N-1:0] sel_o,
  output logic         any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      sel_o[i] = match_i[i] && !found;
      if (match_i[i]) found = 1'b1;
    end
  end
  assign any_o = |sel_o;

  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_sel_any_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i != '0) |-> any_o);
  for (genvar g = 1; g < N; g++) begin : g_low
    p_lowest_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_o[g] |-> (match_i[g-1:0] == '0));
  end
endmodule

// File: rtl/vtlb_top.sv
`timescale 1ns/1ps
module vtlb_top #(
  parameter int unsigned EA_W    = 32,
  parameter int unsigned RA_W    = 32,
  parameter int unsigned PID_W   = 8,
  parameter int unsigned NUM_PID = 3,
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned SIZE_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_ENT),
  localparam int unsigned EPN_W  = EA_W - vtlb_pkg::MIN_OFF,
  localparam int unsigned RPN_W  = RA_W - vtlb_pkg::MIN_OFF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [EA_W-1:0]          ea_i,
  input  logic                     as_i,
  input  logic [NUM_PID*PID_W-1:0] pid_i,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic                     wr_valid_i,
  input  logic                     wr_as_i,
  input  logic [PID_W-1:0]         wr_pid_i,
  input  logic [EPN_W-1:0]         wr_epn_i,
  input  logic [SIZE_W-1:0]        wr_size_i,
  input  logic [RPN_W-1:0]         wr_rpn_i,
  input  logic                     inval_all_i,
  output logic                     hit_o,
  output logic                     miss_o,
  output logic [RA_W-1:0]          ra_o
);
  logic [NUM_ENT-1:0] match, sel;
  logic               any;
  logic [SIZE_W-1:0]  ent_size [NUM_ENT];
  logic [RPN_W-1:0]   ent_rpn  [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    vtlb_entry #(
      .EA_W(EA_W), .PID_W(PID_W), .NUM_PID(NUM_PID), .RPN_W(RPN_W),
      .SIZE_W(SIZE_W), .IDX_W(IDX_W), .MY_IDX(e)
    ) u_ent (
      .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_as_i,
      .wr_pid_i, .wr_epn_i, .wr_size_i, .wr_rpn_i, .inval_all_i, .as_i,
      .epn_i   (ea_i[EA_W-1:vtlb_pkg::MIN_OFF]),
      .pid_i,
      .match_o (match[e]),
      .size_o  (ent_size[e]),
      .rpn_o   (ent_rpn[e])
    );
  end

  vtlb_prio #(.N(NUM_ENT)) u_prio (
    .clk_i, .rst_ni, .match_i(match), .sel_o(sel), .any_o(any)
  );

  // one-hot AND-OR mux of the winning entry
  logic [SIZE_W-1:0] size_sel;
  logic [RPN_W-1:0]  rpn_sel;
  always_comb begin
    size_sel = '0;
    rpn_sel  = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      size_sel |= ent_size[i] & {SIZE_W{sel[i]}};
      rpn_sel  |= ent_rpn[i]  & {RPN_W{sel[i]}};
    end
  end

  logic [RA_W+EA_W-1:0] ea_ext;
  logic [RA_W-1:0]      off_mask, ra_d;
  assign ea_ext = {{RA_W{1'b0}}, ea_i};
  always_comb begin
    int unsigned off;
    off = vtlb_pkg::off_bits(int'(size_sel));
    for (int b = 0; b < RA_W; b++) off_mask[b] = (b < int'(off));
  end
  assign ra_d = ({rpn_sel, {vtlb_pkg::MIN_OFF{1'b0}}} & ~off_mask) |
                (ea_ext[RA_W-1:0] & off_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
      ra_o   <= '0;
    end else begin
      hit_o  <= req_i && any;
      miss_o <= req_i && !any;
      ra_o   <= (req_i && any) ? ra_d : '0;
    end
  end

  p_one_outcome_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (hit_o ^ miss_o));
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!hit_o && !miss_o && ra_o == '0));
  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (ra_o == '0));
  p_offset_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && any) |=> (ra_o[vtlb_pkg::MIN_OFF-1:0] ==
                        $past(ea_i[vtlb_pkg::MIN_OFF-1:0])));
  p_inval_nohit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_all_i |-> ##2 !hit_o);
endmodule

// File: tb/vtlb_top_tb_top.sv
`timescale 1ns/1ps
module vtlb_top_tb_top;
  localparam int RA_W = 36;
  localparam int RPN_W = RA_W - 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic             req_i = 0, as_i = 0, wr_en_i = 0, wr_valid_i = 0, wr_as_i = 0, inval_all_i = 0;
  logic [31:0]      ea_i = '0;
  logic [23:0]      pid_i = '0;
  logic [3:0]       wr_idx_i = '0, wr_size_i = '0;
  logic [7:0]       wr_pid_i = '0;
  logic [19:0]      wr_epn_i = '0;
  logic [RPN_W-1:0] wr_rpn_i = '0;
  logic             hit_o, miss_o;
  logic [RA_W-1:0]  ra_o;

  vtlb_top #(.RA_W(RA_W)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  bit         m_v[16], m_as[16];
  logic [7:0] m_pid[16];
  logic [19:0] m_epn[16];
  logic [3:0] m_sz[16];
  logic [RPN_W-1:0] m_rpn[16];

  function automatic void model(input logic [31:0] ea, input logic as, input logic [23:0] pids,
                                output logic hit, output logic [RA_W-1:0] ra);
    hit = 0; ra = '0;
    for (int i = 0; i < 16; i++) begin
      int off;
      bit pok;
      logic [RA_W-1:0] msk;
      off = 12 + 2 * ((m_sz[i] > 8) ? 8 : int'(m_sz[i]));
      pok = (m_pid[i] == 0) || (m_pid[i] == pids[7:0]) || (m_pid[i] == pids[15:8]) ||
            (m_pid[i] == pids[23:16]);
      if (!hit && m_v[i] && m_as[i] == as && pok &&
          ((({m_epn[i], 12'h000} ^ ea) >> off) == 0)) begin
        hit = 1;
        msk = (RA_W'(1) << off) - 1;
        ra = ({m_rpn[i], 12'h000} & ~msk) | (RA_W'(ea) & msk);
      end
    end
  endfunction

  task automatic chk(input string req, input logic eh, input logic em, input logic [RA_W-1:0] er);
    checks++;
    if (hit_o !== eh || miss_o !== em || ra_o !== er) begin
      errors++;
      $display("FAIL %s: hit=%0b miss=%0b ra=%h expected hit=%0b miss=%0b ra=%h",
               req, hit_o, miss_o, ra_o, eh, em, er);
    end
  endtask

  // one cycle: optional lookup, write and invalidate; called at a falling edge
  task automatic step(input string req, input bit lk, input logic [31:0] ea, input logic as,
                      input logic [23:0] pids, input bit wr, input int idx, input bit v,
                      input logic was, input logic [7:0] wpid, input logic [19:0] wepn,
                      input logic [3:0] wsz, input logic [RPN_W-1:0] wrpn, input bit inv);
    logic eh;
    logic [RA_W-1:0] er;
    model(ea, as, pids, eh, er);
    if (!lk) begin eh = 0; er = '0; end
    req_i = lk; ea_i = ea; as_i = as; pid_i = pids;
    wr_en_i = wr; wr_idx_i = 4'(idx); wr_valid_i = v; wr_as_i = was; wr_pid_i = wpid;
    wr_epn_i = wepn; wr_size_i = wsz; wr_rpn_i = wrpn; inval_all_i = inv;
    @(posedge clk_i);
    if (inv) for (int i = 0; i < 16; i++) m_v[i] = 0;
    else if (wr) begin
      m_v[idx] = v; m_as[idx] = was; m_pid[idx] = wpid; m_epn[idx] = wepn;
      m_sz[idx] = wsz; m_rpn[idx] = wrpn;
    end
    @(negedge clk_i);
    req_i = 0; wr_en_i = 0; inval_all_i = 0;
    chk(req, eh, lk ? !eh : 1'b0, er);
  endtask

  task automatic look(input string req, input logic [31:0] ea, input logic as, input logic [23:0] pids);
    step(req, 1, ea, as, pids, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int idx, input bit v, input logic as, input logic [7:0] pid,
                    input logic [19:0] epn, input logic [3:0] sz, input logic [RPN_W-1:0] rpn);
    step("R9", 0, 0, 0, 0, 1, idx, v, as, pid, epn, sz, rpn, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    if (!done) begin done = 1; $display("CHECKS %0d ERRORS %0d", checks, errors); end
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_as[i] = 0; m_pid[i] = 0; m_epn[i] = 0; m_sz[i] = 0; m_rpn[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    chk("R1 reset", 0, 0, '0);
    look("R1 empty", 32'h1234_5678, 0, 24'h030201);

    // R6 basic 4 KB page, wide real page number
    wr(5, 1, 0, 8'h11, 20'hABCDE, 4'd0, 24'hF12345);
    look("R6 4KB", 32'hABCD_E9A7, 0, 24'h000011);
    look("R6 4KB offset", 32'hABCD_E001, 0, 24'h000011);
    look("R5 4KB next page", 32'hABCD_F001, 0, 24'h000011);
    look("R3 as mismatch", 32'hABCD_E9A7, 1, 24'h000011);
    // R4 pid in slot 2, mismatch, global
    look("R4 slot2", 32'hABCD_E123, 0, 24'h110302);
    look("R4 no pid", 32'hABCD_E123, 0, 24'h040302);
    wr(6, 1, 1, 8'h00, 20'h00100, 4'd1, 24'h000777);
    look("R4 global", 32'h0010_3FFF, 1, 24'h9A8B7C);
    look("R5 16KB", 32'h0010_2ABC, 1, 24'h000000);
    // R5 256 MB and clamped code
    wr(7, 1, 0, 8'h00, 20'h3FFFF, 4'd8, 24'hA00000);
    look("R5 256MB", 32'h3123_4567, 0, 24'h0);
    look("R5 256MB miss", 32'h2123_4567, 0, 24'h0);
    wr(8, 1, 1, 8'h22, 20'h50000, 4'd15, 24'hB00000);
    look("R5 clamp", 32'h5FFF_FFFF, 1, 24'h000022);
    look("R5 clamp miss", 32'h6000_0000, 1, 24'h000022);
    // R7 overlap: entries 3 and 9
    wr(9, 1, 0, 8'h33, 20'h40000, 4'd4, 24'h000009);
    wr(3, 1, 0, 8'h33, 20'h40000, 4'd4, 24'h000003);
    look("R7 lowest", 32'h4001_2345, 0, 24'h000033);
    // R9 removal via valid=0, same-cycle write sees old
    wr(3, 0, 0, 8'h33, 20'h40000, 4'd4, 24'h000003);
    look("R9 removed", 32'h4001_2345, 0, 24'h000033);
    step("R9 same cycle", 1, 32'h4001_2345, 0, 24'h000033, 1, 9, 0, 0, 8'h33, 20'h40000, 4'd4, 24'h9, 0);
    look("R9 after write", 32'h4001_2345, 0, 24'h000033);
    step("R2 idle", 0, 32'h0010_3FFF, 1, 24'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R8 miss", 32'hDEAD_BEEF, 0, 24'h0);
    // R10 invalidate wins over write
    step("R10 inval", 1, 32'h0010_3FFF, 1, 24'h0, 1, 6, 1, 1, 8'h0, 20'h00100, 4'd1, 24'h777, 1);
    look("R10 cleared", 32'h0010_3FFF, 1, 24'h0);
    look("R10 cleared 2", 32'hABCD_E9A7, 0, 24'h000011);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        wr($urandom_range(0, 15), ($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 3)), 20'($urandom), 4'($urandom_range(0, 15)), RPN_W'($urandom));
      end else if (op == 3 && $urandom_range(0, 20) == 0) begin
        step("R10 rand", 1, $urandom, 1'($urandom_range(0, 1)), 24'($urandom), 0, 0, 0, 0, 0, 0, 0, 0, 1);
      end else begin
        int k;
        logic [31:0] ea;
        logic [23:0] p;
        k = $urandom_range(0, 15);
        ea = {m_epn[k], 12'h000} ^ (32'($urandom) >> $urandom_range(4, 31));
        p = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
        if ($urandom_range(0, 1) == 1) p[7:0] = m_pid[k];
        step("R5 R6 R7 rand", ($urandom_range(0, 7) != 0), ea, 1'($urandom_range(0, 1)), p,
             0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end

    if (!done) begin done = 1; $display("CHECKS %0d ERRORS %0d", checks, errors); end
    $finish;
  end
endmodule